// File: doc/BRIEF.md
# Programmable Interrupt Event Generator

This block is a memory-mapped test peripheral that lets software drive two active-low interrupt request lines, a normal request (IRQ) and a fast request (FIQ). Through a simple single-cycle register bus, software can pull either line low at once or arm a per-line down-counter that pulls the line low after a chosen number of clock cycles. A line that has gone low stays low until software writes a release code to a separate clear register.

Each line has its own countdown, so the two schedules run independently. A write to an address that is not one of the four register words returns a decode error and changes nothing. Every decoded access, read or write, returns the same status word in the same cycle.

Top module: `intr_event_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both irq_n and fiq_n are high, no countdown is pending, and a status read returns 0.
- R2: A write to offset 0x0 with data 1 drives irq_n low from the next clock edge. The same write with data 2 drives fiq_n low from the next clock edge.
- R3: A write of N to offset 0x4 (IRQ) or offset 0x8 (FIQ) that is accepted at edge k drives that line low at edge k+N+1. N is taken from the low CNT_W bits of the data, and N = 0 asserts the line at the next edge.
- R4: bus_rdata holds the status word on every decoded access. Bit 0 is IRQ asserted, bit 1 is FIQ asserted, bit 2 is an IRQ countdown pending, bit 3 is an FIQ countdown pending, and the upper bits are 0. The word reflects the state after the previous clock edge.
- R5: A write to offset 0xC with data 1 releases irq_n (high from the next edge). The same write with data 2 releases fiq_n.
- R6: An asserted line stays low until it is released. If a set (immediate or countdown expiry) and a release of the same line happen at the same edge, the line stays low.
- R7: A write to offset 0x0 or offset 0xC with any data other than 1 or 2 changes neither line nor any countdown.
- R8: A schedule write while that line's countdown is pending replaces the remaining count, and the earlier deadline is dropped.
- R9: The two countdowns are independent. An IRQ and an FIQ schedule that expire at the same edge drive both lines low at that edge.
- R10: A valid access whose address is not BASE+0x0, 0x4, 0x8 or 0xC raises bus_err in the same cycle with bus_rdata 0. When that access is a write, it has no effect.
- R11: Reset cancels any pending countdown, so no line falls after reset is released unless software writes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (24) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Status word; 0 on decode error |
| bus_err | output | 1 | Decode error for the current access |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
The assertions take for granted that every bus input is stable across a rising edge. They also assume the base address is aligned to the 16-byte register span, so that offset decoding depends only on the low four address bits. The stimulus changes inputs one time unit after each rising edge and holds them for the whole cycle. It uses only the default aligned base. Misaligned and out-of-window addresses are sent only as deliberate error cases, and each one is followed by a status read that confirms nothing changed.

// File: rtl/ieg_pkg.sv
// Package: shared register selectors and sizes for the interrupt event generator.
// Assumes two lines, line 0 = IRQ and line 1 = FIQ; the release/set code of a line is 1 << index.
package ieg_pkg;
    localparam int NUM_LINES = 2;
    localparam int REG_SPAN  = 16;   // bytes covered by the four word registers

    typedef enum logic [1:0] {
        REG_SET       = 2'd0,
        REG_SCHED_IRQ = 2'd1,
        REG_SCHED_FIQ = 2'd2,
        REG_CLEAR     = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ieg_decode.sv
// Address decoder: flags a hit on one of the four word registers at BASE, else a decode error.
// Assumes BASE is aligned to the register span; only word-aligned offsets 0x0..0xC hit.
module ieg_decode
    import ieg_pkg::*;
#(
    parameter int          ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE = 24'h200000
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel,
    output logic              err
);
    localparam int OFS_W = $clog2(REG_SPAN);

    // Purpose: compare the upper address to the window and check word alignment.
    always_comb begin
        hit = valid && (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]) && (addr[1:0] == 2'b00);
        err = valid && !hit;
        sel = reg_sel_e'(addr[OFS_W-1:2]);
    end
endmodule

// File: rtl/ieg_countdown.sv
// Per-line down-counter: a load arms it with a count; it pulses fire once the count reaches zero.
// Assumes a load has priority over expiry, so a reload in the expiry cycle replaces the deadline.
module ieg_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire,
    output logic             pending
);
    logic [CNT_W-1:0] cnt;
    logic             pend;

    // Purpose: load, decrement and retire the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (load) begin
            cnt  <= load_val;
            pend <= 1'b1;
        end else if (pend) begin
            if (cnt == '0) pend <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Purpose: expiry strobe for the line register.
    assign fire    = pend && (cnt == '0) && !load;
    assign pending = pend;

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cnt != '0 && !load) |=> (pend && cnt == $past(cnt) - 1'b1));
    a_r3_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cnt == '0 && !load) |=> !pend);
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pend && cnt == $past(load_val)));
endmodule

// File: rtl/ieg_line.sv
// Line register: holds one active-low interrupt output; any set wins over a release in the same cycle.
// Assumes set_now, fire and clr come from the same clock domain.
module ieg_line (
    input  logic clk,
    input  logic rst_n,
    input  logic set_now,
    input  logic fire,
    input  logic clr,
    output logic line_n
);
    // Purpose: drive the line low on a set, high on a release, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                line_n <= 1'b1;
        else if (set_now || fire)  line_n <= 1'b0;
        else if (clr)              line_n <= 1'b1;
    end

    a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_n && !clr) |=> !line_n);
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_now && !fire) |=> line_n);
    a_r2_set_low: assert property (@(posedge clk) disable iff (!rst_n)
        (set_now || fire) |=> !line_n);
endmodule

// File: rtl/intr_event_gen.sv
// Interrupt event generator top: decodes the register bus, keeps one countdown and one
// line register per interrupt, and returns a status word on every decoded access.
// Assumes single-cycle accesses with combinational response and a span-aligned BASE.
module intr_event_gen
    import ieg_pkg::*;
#(
    parameter int          ADDR_W = 24,
    parameter int          DATA_W = 32,
    parameter int          CNT_W  = 16,
    parameter logic [ADDR_W-1:0] BASE = 24'h200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq_n,
    output logic              fiq_n
);
    localparam int STAT_W = 2 * NUM_LINES;

    logic                 hit;
    reg_sel_e             sel;
    logic                 wr_hit;
    logic [NUM_LINES-1:0] set_now, clr, load, fire, pending, line_n;

    ieg_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .valid (bus_valid),
        .addr  (bus_addr),
        .hit   (hit),
        .sel   (sel),
        .err   (bus_err)
    );

    assign wr_hit = hit && bus_write;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam reg_sel_e SCHED_SEL = (i == 0) ? REG_SCHED_IRQ : REG_SCHED_FIQ;
        localparam logic [DATA_W-1:0] CODE = DATA_W'(1) << i;

        // Purpose: per-line strobes from the decoded write.
        always_comb begin
            set_now[i] = wr_hit && (sel == REG_SET)   && (bus_wdata == CODE);
            clr[i]     = wr_hit && (sel == REG_CLEAR) && (bus_wdata == CODE);
            load[i]    = wr_hit && (sel == SCHED_SEL);
        end

        ieg_countdown #(.CNT_W(CNT_W)) u_cd (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load[i]),
            .load_val (bus_wdata[CNT_W-1:0]),
            .fire     (fire[i]),
            .pending  (pending[i])
        );

        ieg_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_now (set_now[i]),
            .fire    (fire[i]),
            .clr     (clr[i]),
            .line_n  (line_n[i])
        );
    end

    // Purpose: status word on decoded accesses, zero on decode error or idle.
    always_comb begin
        bus_rdata = '0;
        if (hit) bus_rdata[STAT_W-1:0] = {pending, ~line_n};
    end

    assign irq_n = line_n[0];
    assign fiq_n = line_n[1];

    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (irq_n && fiq_n && pending == '0));
    a_r10_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && bus_write && fire == '0) |=> ($stable(line_n) && $stable(pending)));
endmodule

// File: tb/tb_intr_event_gen.sv
// Scoreboard bench: driver tasks push expected responses, a negedge monitor pops and compares.
module tb_intr_event_gen;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] BASE = 24'h200000;

    typedef struct {
        logic [3:0] st;
        logic       err;
        logic       chk;
        int         req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_n, fiq_n;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    intr_event_gen dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq_n(irq_n), .fiq_n(fiq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic access(input logic wr, input logic [23:0] a, input logic [31:0] d,
                          input logic [3:0] st, input logic e, input logic c, input int r);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        q.push_back('{st: st, err: e, chk: c, req: r});
    endtask

    task automatic rd(input logic [3:0] st, input int r);
        access(1'b0, BASE, 32'h0, st, 1'b0, 1'b1, r);
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [31:0] d, input int r);
        access(1'b1, BASE + 24'(ofs), d, 4'h0, 1'b0, 1'b0, r);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; bus_valid = 1'b0; bus_write = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1; bus_valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: compare each accepted access with the queued expectation.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && bus_valid) begin
            exp_t x;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R4: unexpected access, actual rdata=%h expected none", bus_rdata);
            end else begin
                x = q.pop_front();
                if (x.err) begin
                    if (!bus_err || bus_rdata != 32'h0) begin
                        fails++;
                        $display("FAIL R%0d: err=%b rdata=%h, expected err=1 rdata=0",
                                 x.req, bus_err, bus_rdata);
                    end
                end else if (bus_err) begin
                    fails++;
                    $display("FAIL R%0d: err=1, expected err=0", x.req);
                end else if (x.chk && (bus_rdata != {28'h0, x.st} ||
                                       irq_n != !x.st[0] || fiq_n != !x.st[1])) begin
                    fails++;
                    $display("FAIL R%0d: rdata=%h irq_n=%b fiq_n=%b, expected status=%h",
                             x.req, bus_rdata, irq_n, fiq_n, x.st);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL R1: watchdog expired, actual cycles=%0d expected < 100000", cycles);
            summary();
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        rd(4'b0000, 1);

        // R2: immediate set of each line
        wr(4'h0, 32'd1, 2); rd(4'b0001, 2);
        wr(4'h0, 32'd2, 2); rd(4'b0011, 2);

        // R7: other codes on set and clear registers are ignored
        wr(4'h0, 32'd5, 7); wr(4'hC, 32'd4, 7); wr(4'hC, 32'd3, 7); rd(4'b0011, 7);

        // R5: release each line
        wr(4'hC, 32'd1, 5); rd(4'b0010, 5);
        wr(4'hC, 32'd2, 5); rd(4'b0000, 5);

        // R3 / R4: IRQ after N=3, pending until edge k+4
        wr(4'h4, 32'd3, 3);
        for (int j = 1; j <= 6; j++) rd((j <= 4) ? 4'b0100 : 4'b0001, 3);
        // R6: stays low while idle
        idle(20); rd(4'b0001, 6);
        wr(4'hC, 32'd1, 5); rd(4'b0000, 5);

        // R3: FIQ with N=0 asserts at the next edge
        wr(4'h8, 32'd0, 3); rd(4'b1000, 3); rd(4'b0010, 3);
        wr(4'hC, 32'd2, 5); rd(4'b0000, 5);

        // R8: reschedule replaces the remaining count
        wr(4'h8, 32'd10, 8); idle(2); wr(4'h8, 32'd2, 8);
        for (int j = 1; j <= 5; j++) rd((j <= 3) ? 4'b1000 : 4'b0010, 8);
        wr(4'hC, 32'd2, 8); idle(12); rd(4'b0000, 8);

        // R9: equal deadlines fire in the same cycle
        wr(4'h4, 32'd5, 9); wr(4'h8, 32'd4, 9);
        for (int j = 1; j <= 6; j++) rd((j <= 5) ? 4'b1100 : 4'b0011, 9);
        wr(4'hC, 32'd1, 5); wr(4'hC, 32'd2, 5); rd(4'b0000, 5);

        // R6: expiry and release at the same edge, set wins
        wr(4'h4, 32'd0, 6); wr(4'hC, 32'd1, 6); rd(4'b0001, 6);
        wr(4'hC, 32'd1, 5); rd(4'b0000, 5);

        // R10: decode errors, and an erroring write has no effect
        access(1'b0, BASE + 24'h10, 32'h0, 4'h0, 1'b1, 1'b0, 10);
        access(1'b1, BASE + 24'h20, 32'd1, 4'h0, 1'b1, 1'b0, 10);
        access(1'b1, BASE + 24'h1,  32'd1, 4'h0, 1'b1, 1'b0, 10);
        access(1'b0, 24'h100000,    32'h0, 4'h0, 1'b1, 1'b0, 10);
        rd(4'b0000, 10);

        // R11: reset cancels pending countdowns
        wr(4'h4, 32'd20, 11); wr(4'h8, 32'd20, 11); rd(4'b1100, 11);
        idle(1);
        do_reset();
        rd(4'b0000, 11); idle(40); rd(4'b0000, 11);

        idle(2);
        if (q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R4: %0d responses missing, expected 0", q.size());
        end
        summary();
    end
endmodule